// File: doc/BRIEF.md
# Fixed-Point Bias Add and Rectifying Requantizer

This block sits after a multiply-accumulate array in a fixed-point neural network datapath. Each channel receives a wide signed accumulator word. The block adds a per-channel bias, which is fixed when the block is built. It then reduces the sum to a narrow activation word and applies a rectifying nonlinearity during that reduction. The nonlinearity is either a plain rectifier or a rectifier with an upper limit of six.

The datapath is purely combinational. It has no clock and no reset, and an output settles within the same cycle as its input. The number of channels, the accumulator width, the activation width and the number of weight fraction bits are parameters. The per-channel biases are given as one packed parameter vector. A second parameter selects the nonlinearity.

Top module: `rq_bias_relu6`

## Requirements
- R1: Channel k forms its sum as acc + bias_k at the full ACC_W width, modulo 2^ACC_W. A zero bias leaves the accumulator unchanged, a negative bias subtracts its magnitude, and a positive bias adds it.
- R2: When bit ACC_W-1 of a channel's sum is 1, that channel's output is all zeros, in both modes.
- R3: In plain rectifier mode (ACT_KIND = ACT_RELU), a sum whose bit ACC_W-1 is 0 gives the output {sum[ACC_W-1], sum[WFRAC+ACT_W-2 : WFRAC]}. The output's top bit is therefore 0.
- R4: Sum bits above position WFRAC+ACT_W-2 are discarded with no saturation. A large positive sum wraps into the low ACT_W-1 bits.
- R5: In limited mode (ACT_KIND = ACT_RELU6), a non-negative sum that is not below the integer 6 gives the output 6. The 6 is compared against the unscaled sum.
- R6: In limited mode, a non-negative sum below 6 gives the same sliced value as R3.
- R7: Channel k reads acc_i[k*ACC_W +: ACC_W], uses bias word BIAS_TABLE[k*ACC_W +: ACC_W] and drives act_o[k*ACT_W +: ACT_W]. Channels do not interact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | NCH*ACC_W | Packed signed accumulator words, channel 0 in the low bits |
| act_o | output | NCH*ACT_W | Packed activation words, channel 0 in the low bits |

## Verification
The bench uses two instances. One applies the plain rectifier with eight fraction bits. The other applies the limited rectifier with zero fraction bits, so that each small sum shows up directly at the output. The stimulus includes:
- negative sums, including the most negative word, which separate the zeroing path from the slice path;
- sums of exactly 0, 5, 6 and 7, which locate the limit comparison against the unscaled value;
- large positive sums, which show that high bits wrap instead of saturating;
- accumulators that a bias pushes across zero or past the top of the signed range, which confirm that the addition runs at full width before the sign test.

A final pattern gives each channel a different value to expose any mixing or swapping of lanes.

// File: rtl/rq_pkg.sv
// Package: shared types for the bias/requantize datapath.
// Assumes nothing beyond IEEE 1800-2017.
package rq_pkg;
    // Selects the nonlinearity applied while narrowing the sum.
    typedef enum logic {
        ACT_RELU  = 1'b0,
        ACT_RELU6 = 1'b1
    } act_kind_e;
endpackage

// File: rtl/rq_bias_add.sv
// Module: rq_bias_add
// Adds a build-time signed bias to one accumulator word at full width.
// The result wraps modulo 2^ACC_W. Assumes BIAS fits in ACC_W bits.
module rq_bias_add #(
    parameter int                  ACC_W = 32,
    parameter logic [ACC_W-1:0]    BIAS  = '0
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] sum_o
);
    localparam logic [ACC_W-1:0] MAG = BIAS[ACC_W-1] ? (~BIAS + 1'b1) : BIAS;

    generate
        if (BIAS == '0) begin : g_zero
            // Zero bias: pass the accumulator straight through.
            assign sum_o = acc_i;
        end else if (BIAS[ACC_W-1]) begin : g_neg
            // Negative bias: subtract its magnitude.
            assign sum_o = acc_i - MAG;
        end else begin : g_pos
            // Positive bias: add it.
            assign sum_o = acc_i + MAG;
        end
    endgenerate
endmodule

// File: rtl/rq_relu_slice.sv
// Module: rq_relu_slice
// Rectifies a sum and narrows it to ACT_W bits. The low ACT_W-1 bits are
// taken from position WFRAC upward, with the sum's sign bit placed on top.
// Higher bits are dropped (wrap). Assumes WFRAC + ACT_W - 1 <= ACC_W - 1.
module rq_relu_slice #(
    parameter int ACC_W = 32,
    parameter int ACT_W = 8,
    parameter int WFRAC = 8
) (
    input  logic [ACC_W-1:0] sum_i,
    output logic             neg_o,
    output logic [ACT_W-1:0] act_o
);
    localparam int LO = WFRAC;
    localparam int HI = WFRAC + ACT_W - 2;

    logic unused_sum_bits;

    // Bits outside the slice and the sign bit carry no meaning here.
    assign unused_sum_bits = ^sum_i;

    // Sign test on the full-width sum.
    assign neg_o = sum_i[ACC_W-1];

    // Zero on negative, else sign bit over the positioned slice.
    always_comb begin
        if (neg_o) act_o = '0;
        else       act_o = {sum_i[ACC_W-1], sum_i[HI:LO]};
    end
endmodule

// File: rtl/rq_clamp6.sv
// Module: rq_clamp6
// Replaces a rectified value by the integer 6 when the unscaled sum is
// non-negative and at least 6. Assumes ACT_W >= 4, so that 6 fits.
module rq_clamp6 #(
    parameter int ACC_W = 32,
    parameter int ACT_W = 8
) (
    input  logic [ACC_W-1:0] sum_i,
    input  logic             neg_i,
    input  logic [ACT_W-1:0] slice_i,
    output logic [ACT_W-1:0] act_o
);
    localparam logic [ACC_W-1:0] SIX_W = ACC_W'(6);
    localparam logic [ACT_W-1:0] SIX_A = ACT_W'(6);

    // Limit: compare the raw non-negative sum against 6.
    always_comb begin
        if (!neg_i && (sum_i >= SIX_W)) act_o = SIX_A;
        else                            act_o = slice_i;
    end
endmodule

// File: rtl/rq_lane.sv
// Module: rq_lane
// One channel: bias add, rectify and slice, then an optional limit at 6.
// ACT_KIND selects the variant at build time.
module rq_lane
    import rq_pkg::*;
#(
    parameter int               ACC_W    = 32,
    parameter int               ACT_W    = 8,
    parameter int               WFRAC    = 8,
    parameter act_kind_e        ACT_KIND = ACT_RELU6,
    parameter logic [ACC_W-1:0] BIAS     = '0
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] sum_o,
    output logic [ACT_W-1:0] act_o
);
    logic             neg;
    logic [ACT_W-1:0] sliced;

    rq_bias_add #(.ACC_W(ACC_W), .BIAS(BIAS)) u_add (
        .acc_i (acc_i),
        .sum_o (sum_o)
    );

    rq_relu_slice #(.ACC_W(ACC_W), .ACT_W(ACT_W), .WFRAC(WFRAC)) u_slice (
        .sum_i (sum_o),
        .neg_o (neg),
        .act_o (sliced)
    );

    generate
        if (ACT_KIND == ACT_RELU6) begin : g_lim
            // Limited rectifier: route through the clamp.
            rq_clamp6 #(.ACC_W(ACC_W), .ACT_W(ACT_W)) u_clamp (
                .sum_i   (sum_o),
                .neg_i   (neg),
                .slice_i (sliced),
                .act_o   (act_o)
            );
        end else begin : g_plain
            // Plain rectifier: the slice is the result.
            assign act_o = sliced;
        end
    endgenerate
endmodule

// File: rtl/rq_bias_relu6.sv
// Module: rq_bias_relu6 (top)
// NCH independent lanes that each add a bias and requantize with a
// rectifier. Purely combinational. BIAS_TABLE packs one ACC_W word per
// channel, with channel 0 in the low bits.
module rq_bias_relu6
    import rq_pkg::*;
#(
    parameter int                      NCH        = 4,
    parameter int                      ACC_W      = 32,
    parameter int                      ACT_W      = 8,
    parameter int                      WFRAC      = 8,
    parameter act_kind_e               ACT_KIND   = ACT_RELU6,
    parameter logic [NCH*ACC_W-1:0]    BIAS_TABLE = '0
) (
    input  logic [NCH*ACC_W-1:0] acc_i,
    output logic [NCH*ACT_W-1:0] act_o
);
    localparam int SUM_BITS = NCH * ACC_W;

    logic [SUM_BITS-1:0] lane_sum;

    // One lane per channel, each with its own bias word.
    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            rq_lane #(
                .ACC_W    (ACC_W),
                .ACT_W    (ACT_W),
                .WFRAC    (WFRAC),
                .ACT_KIND (ACT_KIND),
                .BIAS     (BIAS_TABLE[k*ACC_W +: ACC_W])
            ) u_lane (
                .acc_i (acc_i[k*ACC_W +: ACC_W]),
                .sum_o (lane_sum[k*ACC_W +: ACC_W]),
                .act_o (act_o[k*ACT_W +: ACT_W])
            );
        end
    endgenerate
endmodule

// File: rtl/rq_bias_relu6_chk.sv
// Module: rq_bias_relu6_chk
// Assertion checker bound to rq_bias_relu6. It relates the inputs, the
// per-lane sums and the outputs. Combinational, so immediate checks only.
module rq_bias_relu6_chk
    import rq_pkg::*;
#(
    parameter int                   NCH        = 4,
    parameter int                   ACC_W      = 32,
    parameter int                   ACT_W      = 8,
    parameter act_kind_e            ACT_KIND   = ACT_RELU6,
    parameter logic [NCH*ACC_W-1:0] BIAS_TABLE = '0
) (
    input logic [NCH*ACC_W-1:0] acc_flat,
    input logic [NCH*ACC_W-1:0] sum_flat,
    input logic [NCH*ACT_W-1:0] act_flat
);
    // Per-channel invariants over input, sum and output.
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            // R1
            bias_passthru_chk: assert (acc_flat[k*ACC_W +: ACC_W] != '0 ||
                sum_flat[k*ACC_W +: ACC_W] == BIAS_TABLE[k*ACC_W +: ACC_W])
                else $error("bias word not seen on zero accumulator");
            // R2
            neg_zero_chk: assert (!sum_flat[k*ACC_W + ACC_W - 1] ||
                act_flat[k*ACT_W +: ACT_W] == '0)
                else $error("negative sum gave nonzero output");
            // R3
            top_bit_zero_chk: assert (act_flat[k*ACT_W + ACT_W - 1] == 1'b0)
                else $error("output top bit set");
            // R5
            clamp_six_chk: assert (ACT_KIND != ACT_RELU6 ||
                sum_flat[k*ACC_W + ACC_W - 1] ||
                sum_flat[k*ACC_W +: ACC_W] < ACC_W'(6) ||
                act_flat[k*ACT_W +: ACT_W] == ACT_W'(6))
                else $error("limit not applied");
            // R6
            limit_bound_chk: assert (ACT_KIND != ACT_RELU6 ||
                act_flat[k*ACT_W +: ACT_W] <= ACT_W'(6))
                else $error("limited output above 6");
        end
    end
endmodule

bind rq_bias_relu6 rq_bias_relu6_chk #(
    .NCH        (NCH),
    .ACC_W      (ACC_W),
    .ACT_W      (ACT_W),
    .ACT_KIND   (ACT_KIND),
    .BIAS_TABLE (BIAS_TABLE)
) u_chk (
    .acc_flat (acc_i),
    .sum_flat (lane_sum),
    .act_flat (act_o)
);

// File: tb/sim_rq_bias_relu6.sv
// Directed bench. u0 is the plain rectifier with 8 fraction bits; u1 is
// the limited rectifier with 0 fraction bits. Both get the same stimulus.
module sim_rq_bias_relu6;
    import rq_pkg::*;

    localparam int NCH = 4;
    localparam int AW  = 32;
    localparam int VW  = 8;
    localparam logic [NCH*AW-1:0] B0 = {32'h0000_0005, 32'hFFFF_FE80,
                                        32'h0000_0100, 32'h0000_0000};
    localparam logic [NCH*AW-1:0] B1 = {32'h0000_0000, 32'hFFFF_FFFE,
                                        32'h0000_0003, 32'h0000_0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH*AW-1:0] acc;
    logic [NCH*VW-1:0] out0, out1;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rq_bias_relu6 #(.NCH(NCH), .ACC_W(AW), .ACT_W(VW), .WFRAC(8),
        .ACT_KIND(ACT_RELU), .BIAS_TABLE(B0)) u0 (.acc_i(acc), .act_o(out0));
    rq_bias_relu6 #(.NCH(NCH), .ACC_W(AW), .ACT_W(VW), .WFRAC(0),
        .ACT_KIND(ACT_RELU6), .BIAS_TABLE(B1)) u1 (.acc_i(acc), .act_o(out1));

    function automatic logic [VW-1:0] model(logic [AW-1:0] a, logic [AW-1:0] b,
                                            int wf, bit lim);
        logic [AW-1:0] s;
        s = a + b;
        if (s[AW-1]) return '0;
        if (lim && s >= 32'd6) return 8'd6;
        return 8'((s >> wf) & 32'h7F);
    endfunction

    task automatic apply_check(input logic [AW-1:0] a0, a1, a2, a3, input string req);
        logic [VW-1:0] e;
        acc = {a3, a2, a1, a0};
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            e = model(acc[k*AW +: AW], B0[k*AW +: AW], 8, 1'b0);
            vectors++;
            if (out0[k*VW +: VW] !== e) begin
                miscompares++;
                $display("FAIL %s u0 ch%0d acc=%h got %h exp %h", req, k,
                         acc[k*AW +: AW], out0[k*VW +: VW], e);
            end
            e = model(acc[k*AW +: AW], B1[k*AW +: AW], 0, 1'b1);
            vectors++;
            if (out1[k*VW +: VW] !== e) begin
                miscompares++;
                $display("FAIL %s u1 ch%0d acc=%h got %h exp %h", req, k,
                         acc[k*AW +: AW], out1[k*VW +: VW], e);
            end
        end
    endtask

    // R1: zero accumulators show the bias alone
    task automatic t_initial;
        apply_check(0, 0, 0, 0, "R1");
    endtask

    // R2: negative sums, including the most negative word
    task automatic t_negative;
        apply_check(32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FF00, 32'hFFFF_FFF0, "R2");
    endtask

    // R5/R6: the boundary around raw 6
    task automatic t_six_edge;
        apply_check(32'd5, 32'd5, 32'd5, 32'd5, "R6");
        apply_check(32'd6, 32'd6, 32'd6, 32'd6, "R5");
        apply_check(32'd7, 32'd2, 32'd8, 32'd1, "R5");
    endtask

    // R3/R4: slice position and wrap of the high bits
    task automatic t_wrap;
        apply_check(32'h0001_2345, 32'h0000_7F00, 32'h7FFF_FFFF, 32'h0000_8000, "R4");
        apply_check(32'h0000_0300, 32'h0000_0A55, 32'h0000_0400, 32'h0000_00FF, "R3");
    endtask

    // R1: bias pushes across zero or past the top of the signed range
    task automatic t_bias_cross;
        apply_check(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_017F, 32'h7FFF_FFFB, "R1");
        apply_check(32'hFFFF_FF00, 32'hFFFF_FFFD, 32'h0000_0180, 32'hFFFF_FFFB, "R1");
    endtask

    // R7: distinct value per lane
    task automatic t_lanes;
        apply_check(32'h0000_0200, 32'h0000_0001, 32'h0000_0600, 32'h0000_0104, "R7");
    endtask

    // Run the directed scenarios after reset.
    initial begin
        acc = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        t_initial();
        t_negative();
        t_six_edge();
        t_wrap();
        t_bias_cross();
        t_lanes();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule